// File: doc/BRIEF.md
# Conversion Result Window Guard

This block watches the stream of raw conversion results that a converter sequencer produces and flags any result that leaves a programmed voltage window. Each result arrives with a single-cycle valid strobe, its 12-bit raw code, the number of the input channel it was taken from, and a tag that says whether it came from the regular sequence or from an injected (priority) sequence. The window test runs on the raw code, before any left/right alignment or offset subtraction is applied further down the path. The result is therefore the same whichever alignment the data register uses.

The guard can be limited in two ways. It can watch one channel only, or every channel. It can also be enabled on its own for regular results and for injected results. When a qualifying result lies strictly below the low bound or strictly above the high bound, a sticky status flag is set. The flag stays set until software writes a zero to it. An interrupt line follows the flag whenever the interrupt enable is on. The flag is set whether or not the interrupt is enabled.

Top module: `adc_window_guard`

## Requirements
- R1: A qualifying result whose code is strictly less than `thr_low` sets `wd_flag`, and the flag is seen high from the first clock edge after the result's valid cycle.
- R2: A qualifying result whose code is strictly greater than `thr_high` sets `wd_flag` at that same edge.
- R3: A result equal to either bound, or lying between the bounds, leaves `wd_flag` unchanged. This includes the case where both bounds are equal.
- R4: With `one_chan_mode` = 1, only results whose `res_chan` equals `guard_chan` can set the flag. With `one_chan_mode` = 0, results from any channel (0 to 31) can set it.
- R5: `res_inj` = 0 marks a regular result, which is guarded only when `reg_guard_en` = 1. `res_inj` = 1 marks an injected result, which is guarded only when `inj_guard_en` = 1.
- R6: Once set, `wd_flag` stays set through later in-window results. A write (`clr_wr` = 1) with `clr_val` = 0 clears it at the next edge. A write with `clr_val` = 1 leaves it set.
- R7: If a qualifying out-of-window result and a clearing write happen in the same cycle, the flag ends set.
- R8: `wd_irq` equals `wd_flag` AND `irq_en`, with no register in between. The flag is set even while `irq_en` = 0.
- R9: Synchronous active-high `rst` clears `wd_flag`, and so `wd_irq` as well.
- R10: Cycles with `res_vld` = 0 never set the flag, whatever `res_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | Conversion result valid strobe |
| res_data | input | 12 | Raw (unaligned) conversion code |
| res_chan | input | 5 | Channel the result was taken from |
| res_inj | input | 1 | 0 = regular result, 1 = injected result |
| thr_high | input | 12 | Upper window bound |
| thr_low | input | 12 | Lower window bound |
| one_chan_mode | input | 1 | 1 = guard only `guard_chan`, 0 = guard all channels |
| guard_chan | input | 5 | Channel guarded in single-channel mode |
| reg_guard_en | input | 1 | Guard regular results |
| inj_guard_en | input | 1 | Guard injected results |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Status write strobe |
| clr_val | input | 1 | Status write data (0 clears the flag) |
| wd_flag | output | 1 | Sticky out-of-window status |
| wd_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that configuration inputs are quasi-static: they do not change in the same cycle as a valid result they are meant to govern. They also assume that `res_vld` is a one-cycle strobe per result. The bench respects this. It changes bounds, channel selection and enables only on falling edges, one cycle before the valid strobe. It clears the flag before each table vector, so every expected value depends only on that vector. The same-cycle set and clear case is driven on purpose, in a single directed step.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int unsigned AWD_DATA_W = 12;
    localparam int unsigned AWD_CH_W   = 5;

    typedef enum logic {
        GRP_REGULAR  = 1'b0,
        GRP_INJECTED = 1'b1
    } awd_grp_e;

    typedef struct packed {
        logic below;
        logic above;
    } awd_cmp_t;

    function automatic logic awd_outside(input awd_cmp_t c);
        return c.below | c.above;
    endfunction

endpackage

// File: rtl/awd_qualify.sv
module awd_qualify
    import awd_pkg::*;
#(
    parameter int unsigned CH_W = AWD_CH_W
) (
    input  logic            vld,
    input  logic [CH_W-1:0] chan,
    input  awd_grp_e        grp,
    input  logic            one_chan,
    input  logic [CH_W-1:0] sel_chan,
    input  logic            reg_en,
    input  logic            inj_en,
    output logic            qual
);
    localparam int unsigned NGRP = 2;

    logic [NGRP-1:0] grp_on;
    logic            grp_ok;
    logic            chan_ok;

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            if (g == int'(GRP_INJECTED)) begin : g_inj
                assign grp_on[g] = inj_en;
            end else begin : g_reg
                assign grp_on[g] = reg_en;
            end
        end
    endgenerate

    always_comb begin
        grp_ok  = grp_on[grp];
        chan_ok = !one_chan || (chan == sel_chan);
        qual    = vld && grp_ok && chan_ok;
    end
endmodule

// File: rtl/awd_window.sv
module awd_window
    import awd_pkg::*;
#(
    parameter int unsigned DATA_W = AWD_DATA_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output awd_cmp_t          cmp
);
    always_comb begin
        cmp.below = data < lo;
        cmp.above = data > hi;
    end

    always_comb begin
        assert_exclusive_R3: assert (!(cmp.below && cmp.above) || (lo > hi))
            else $error("window compare reports both sides with ordered bounds");
    end
endmodule

// File: rtl/awd_status.sv
module awd_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr_wr,
    input  logic clr_val,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic clr_req;

    assign clr_req = clr_wr && !clr_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && irq_en;

    // R1 and R2: a hit shows at the next edge; R7: set wins over clear
    assert_hit_sets_R1: assert property (@(posedge clk) disable iff (rst)
        set |=> flag)
        else $error("hit did not set flag");

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        flag && !(clr_wr && !clr_val) |=> flag)
        else $error("flag dropped without clear");

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr_wr && !clr_val && !set |=> !flag)
        else $error("clear write ignored");

    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set))
        else $error("flag rose without a hit");

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag && irq_en)
        else $error("irq without flag and enable");
endmodule

// File: rtl/adc_window_guard.sv
module adc_window_guard
    import awd_pkg::*;
#(
    parameter int unsigned DATA_W = AWD_DATA_W,
    parameter int unsigned CH_W   = AWD_CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic              res_inj,
    input  logic [DATA_W-1:0] thr_high,
    input  logic [DATA_W-1:0] thr_low,
    input  logic              one_chan_mode,
    input  logic [CH_W-1:0]   guard_chan,
    input  logic              reg_guard_en,
    input  logic              inj_guard_en,
    input  logic              irq_en,
    input  logic              clr_wr,
    input  logic              clr_val,
    output logic              wd_flag,
    output logic              wd_irq
);
    awd_grp_e grp;
    awd_cmp_t cmp;
    logic     qual;
    logic     hit;

    assign grp = res_inj ? GRP_INJECTED : GRP_REGULAR;

    awd_qualify #(.CH_W(CH_W)) u_qualify (
        .vld      (res_vld),
        .chan     (res_chan),
        .grp      (grp),
        .one_chan (one_chan_mode),
        .sel_chan (guard_chan),
        .reg_en   (reg_guard_en),
        .inj_en   (inj_guard_en),
        .qual     (qual)
    );

    awd_window #(.DATA_W(DATA_W)) u_window (
        .data (res_data),
        .lo   (thr_low),
        .hi   (thr_high),
        .cmp  (cmp)
    );

    assign hit = qual && awd_outside(cmp);

    awd_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set     (hit),
        .clr_wr  (clr_wr),
        .clr_val (clr_val),
        .irq_en  (irq_en),
        .flag    (wd_flag),
        .irq     (wd_irq)
    );

    assert_other_chan_R4: assert property (@(posedge clk) disable iff (rst)
        res_vld && one_chan_mode && (res_chan != guard_chan) && !wd_flag
        |=> !wd_flag)
        else $error("unguarded channel set flag");

    assert_grp_off_R5: assert property (@(posedge clk) disable iff (rst)
        ((res_inj && !inj_guard_en) || (!res_inj && !reg_guard_en)) && !wd_flag
        |=> !wd_flag)
        else $error("disabled group set flag");

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !res_vld && !wd_flag |=> !wd_flag)
        else $error("flag set without valid result");
endmodule

// File: tb/adc_window_guard_tb.sv
module adc_window_guard_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        res_vld;
    logic [11:0] res_data;
    logic [4:0]  res_chan;
    logic        res_inj;
    logic [11:0] thr_high;
    logic [11:0] thr_low;
    logic        one_chan_mode;
    logic [4:0]  guard_chan;
    logic        reg_guard_en;
    logic        inj_guard_en;
    logic        irq_en;
    logic        clr_wr;
    logic        clr_val;
    logic        wd_flag;
    logic        wd_irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    adc_window_guard u_dut (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_data(res_data),
        .res_chan(res_chan), .res_inj(res_inj), .thr_high(thr_high),
        .thr_low(thr_low), .one_chan_mode(one_chan_mode),
        .guard_chan(guard_chan), .reg_guard_en(reg_guard_en),
        .inj_guard_en(inj_guard_en), .irq_en(irq_en), .clr_wr(clr_wr),
        .clr_val(clr_val), .wd_flag(wd_flag), .wd_irq(wd_irq)
    );

    typedef struct packed {
        logic [11:0] data;
        logic [4:0]  ch;
        logic        inj;
        logic [11:0] hi;
        logic [11:0] lo;
        logic        one;
        logic [4:0]  gch;
        logic        ren;
        logic        ien;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{12'h3FF, 5'd0,  1'b0, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 4'd1}, // R1 just below
        '{12'h000, 5'd3,  1'b0, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 4'd1}, // R1 zero code
        '{12'h400, 5'd0,  1'b0, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 equal low
        '{12'hC00, 5'd0,  1'b0, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 equal high
        '{12'h800, 5'd0,  1'b0, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 inside
        '{12'hC01, 5'd0,  1'b0, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 4'd2}, // R2 just above
        '{12'h500, 5'd0,  1'b0, 12'h500, 12'h500, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 zero-width window
        '{12'h501, 5'd0,  1'b0, 12'h500, 12'h500, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 4'd2}, // R2 zero-width window
        '{12'h001, 5'd5,  1'b0, 12'hC00, 12'h400, 1'b1, 5'd5, 1'b1, 1'b1, 1'b1, 4'd4}, // R4 guarded channel
        '{12'h001, 5'd6,  1'b0, 12'hC00, 12'h400, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, 4'd4}, // R4 other channel
        '{12'hFFF, 5'd31, 1'b0, 12'hC00, 12'h400, 1'b0, 5'd5, 1'b1, 1'b1, 1'b1, 4'd4}, // R4 all channels
        '{12'hFFF, 5'd0,  1'b1, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 injected off
        '{12'hFFF, 5'd0,  1'b1, 12'hC00, 12'h400, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 4'd5}  // R5 injected on
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [11:0] d, input logic [4:0] ch, input logic inj);
        @(negedge clk);
        res_vld = 1'b1; res_data = d; res_chan = ch; res_inj = inj;
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic status_write(input logic v);
        @(negedge clk);
        clr_wr = 1'b1; clr_val = v;
        @(negedge clk);
        clr_wr = 1'b0;
    endtask

    task automatic std_cfg();
        thr_high = 12'hC00; thr_low = 12'h400; one_chan_mode = 1'b0;
        guard_chan = 5'd0; reg_guard_en = 1'b1; inj_guard_en = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; res_vld = 1'b0; res_data = '0; res_chan = '0; res_inj = 1'b0;
        irq_en = 1'b1; clr_wr = 1'b0; clr_val = 1'b1;
        std_cfg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset flag", wd_flag, 1'b0);
        check("R9 reset irq", wd_irq, 1'b0);

        for (int i = 0; i < NV; i++) begin
            status_write(1'b0);
            thr_high = VECS[i].hi; thr_low = VECS[i].lo;
            one_chan_mode = VECS[i].one; guard_chan = VECS[i].gch;
            reg_guard_en = VECS[i].ren; inj_guard_en = VECS[i].ien;
            apply(VECS[i].data, VECS[i].ch, VECS[i].inj);
            check($sformatf("R%0d vector %0d flag", VECS[i].req, i), wd_flag, VECS[i].exp);
            check($sformatf("R%0d vector %0d irq", VECS[i].req, i), wd_irq, VECS[i].exp);
        end

        // R8: flag sets with irq disabled, irq follows enable at once
        std_cfg();
        irq_en = 1'b0;
        status_write(1'b0);
        apply(12'h000, 5'd1, 1'b0);
        check("R8 flag with irq off", wd_flag, 1'b1);
        check("R8 irq masked", wd_irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R8 irq enabled", wd_irq, 1'b1);

        // R6: sticky through in-window results, write of one keeps, zero clears
        apply(12'h800, 5'd1, 1'b0);
        check("R6 sticky after inside", wd_flag, 1'b1);
        status_write(1'b1);
        check("R6 write one keeps", wd_flag, 1'b1);
        status_write(1'b0);
        check("R6 write zero clears", wd_flag, 1'b0);

        // R7: set and clear in the same cycle
        @(negedge clk);
        res_vld = 1'b1; res_data = 12'h000; res_chan = 5'd2; res_inj = 1'b0;
        clr_wr = 1'b1; clr_val = 1'b0;
        @(negedge clk);
        res_vld = 1'b0; clr_wr = 1'b0;
        check("R7 set beats clear", wd_flag, 1'b1);

        // R10: out-of-window data with valid low
        status_write(1'b0);
        @(negedge clk);
        res_vld = 1'b0; res_data = 12'hFFF;
        repeat (2) @(negedge clk);
        check("R10 no valid no flag", wd_flag, 1'b0);

        // R9: reset while flag is set
        apply(12'hFFF, 5'd0, 1'b0);
        check("R9 flag before reset", wd_flag, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears flag", wd_flag, 1'b0);
        check("R9 reset clears irq", wd_irq, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule